// File: doc/BRIEF.md
# GPIO interrupt and wake detector

This block watches one bank of already-synchronized GPIO input levels and turns them into interrupt events. Each pin can be armed for rising edges, falling edges or both, or switched into level mode where a programmable polarity picks whether high or low is the active level. Every detected event latches a bit in an interrupt-source vector. The bits that are both latched and enabled by the interrupt mask are ORed into a single request line for the parent interrupt controller.

A second status vector records wake events. A wake bit latches on any event of a pin whose wake-enable bit is set, independent of that pin's interrupt mask. Both status vectors are cleared by writing ones. Configuration and status sit behind a simple word-indexed write port and a combinational read port. Pad sampling and output drive are handled elsewhere.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset every register reads 0 at all eight indices and `irq_out` is 0.
- R2: With a pin in edge mode (mode bit 0) and its rise-enable bit (index 2) set, a sampled 0-to-1 change of that pin sets its source bit (index 0) at the same clock edge that first samples the high level.
- R3: With a pin in edge mode and its fall-enable bit (index 3) set, a sampled 1-to-0 change sets its source bit; with both enables set, either change does.
- R4: Pin changes on a pin whose rise and fall enables are both 0 and whose mode bit is 0 leave the source and wake vectors unchanged; this holds directly after reset.
- R5: With the mode bit (index 4) at 1, the source bit is set on every cycle the pin is at its active level: high when the polarity bit (index 5) is 0, low when it is 1; clearing it while the level persists has no lasting effect.
- R6: An edge-mode source bit stays set after the pin returns until a 1 is written to that bit at index 0; bits written with 0 are unaffected.
- R7: `irq_out` is 1 exactly when some bit is set in both the source vector and the interrupt mask (index 1, 1 = enabled).
- R8: A wake bit (index 7) is set by any event on a pin whose wake-enable bit (index 6) is 1, regardless of its interrupt mask, never for a pin whose wake-enable is 0, and is cleared by writing 1.
- R9: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Indices 1 to 6 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPINS | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write index |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read index |
| rd_data | output | DATA_W | Register read data, combinational |
| irq_out | output | 1 | Request to the parent interrupt controller |

## Verification
The bench targets the cycle where a clear and a fresh event collide: a design that let the clear win would drop an interrupt. It clears a level-mode bit while the pin stays active, which a design that treats level mode like a latched edge would leave cleared. It checks that the wake status follows the wake-enable and not the interrupt mask, so a design that gated wake through the mask would miss wake-ups. It also checks polarity inversion and that nothing fires after reset before any enable is written.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   // Register indices; the status and configuration blocks decode these.
   typedef enum logic [2:0] {
      RG_SRC   = 3'd0,
      RG_IEN   = 3'd1,
      RG_RISE  = 3'd2,
      RG_FALL  = 3'd3,
      RG_LMODE = 3'd4,
      RG_LLOW  = 3'd5,
      RG_WEN   = 3'd6,
      RG_WSRC  = 3'd7
   } reg_sel_e;

   localparam int CFG_FIRST = 1;
   localparam int CFG_LAST  = 6;

endpackage

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
   import gpio_evt_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NPINS-1:0]  wr_data,
   output logic [NPINS-1:0]  ien,
   output logic [NPINS-1:0]  rise_en,
   output logic [NPINS-1:0]  fall_en,
   output logic [NPINS-1:0]  lmode,
   output logic [NPINS-1:0]  llow,
   output logic [NPINS-1:0]  wen
);

   logic [NPINS-1:0] cfg_q [CFG_FIRST:CFG_LAST];

   for (genvar r = CFG_FIRST; r <= CFG_LAST; r++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(r);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[r] <= '0;
         else if (wr_en && (wr_addr == MY_IDX))
            cfg_q[r] <= wr_data;
      end
   end

   assign ien     = cfg_q[int'(RG_IEN)];
   assign rise_en = cfg_q[int'(RG_RISE)];
   assign fall_en = cfg_q[int'(RG_FALL)];
   assign lmode   = cfg_q[int'(RG_LMODE)];
   assign llow    = cfg_q[int'(RG_LLOW)];
   assign wen     = cfg_q[int'(RG_WEN)];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_lvl,
   input  logic [NPINS-1:0] rise_en,
   input  logic [NPINS-1:0] fall_en,
   input  logic [NPINS-1:0] lmode,
   input  logic [NPINS-1:0] llow,
   output logic [NPINS-1:0] pin_q,
   output logic [NPINS-1:0] evt
);

   // Previous sample, used only for edge comparison.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_q <= '0;
      else
         pin_q <= pin_lvl;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic went_up;
      logic went_dn;
      logic lvl_act;
      logic edge_hit;
      assign went_up  = pin_lvl[i] & ~pin_q[i];
      assign went_dn  = ~pin_lvl[i] & pin_q[i];
      assign lvl_act  = pin_lvl[i] ^ llow[i];
      assign edge_hit = (rise_en[i] & went_up) | (fall_en[i] & went_dn);
      assign evt[i]   = lmode[i] ? lvl_act : edge_hit;
   end

endmodule

// File: rtl/gpio_evt_w1c.sv
module gpio_evt_w1c #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] set_vec,
   input  logic [NPINS-1:0] clr_vec,
   output logic [NPINS-1:0] stat_q
);

   // Set has priority over clear on the same bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= '0;
      else
         stat_q <= (stat_q & ~clr_vec) | set_vec;
   end

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
   import gpio_evt_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter bit IRQ_OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_lvl,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_out
);

   localparam logic [ADDR_W-1:0] A_SRC   = ADDR_W'(RG_SRC);
   localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(RG_IEN);
   localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(RG_RISE);
   localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(RG_FALL);
   localparam logic [ADDR_W-1:0] A_LMODE = ADDR_W'(RG_LMODE);
   localparam logic [ADDR_W-1:0] A_LLOW  = ADDR_W'(RG_LLOW);
   localparam logic [ADDR_W-1:0] A_WEN   = ADDR_W'(RG_WEN);
   localparam logic [ADDR_W-1:0] A_WSRC  = ADDR_W'(RG_WSRC);

   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("gpio_evt_bank: NPINS must lie in 1..DATA_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("gpio_evt_bank: ADDR_W must be at least 3");
   end

   logic [NPINS-1:0] wr_bits;
   logic [NPINS-1:0] ien_w, rise_en_w, fall_en_w, lmode_w, llow_w, wen_w;
   logic [NPINS-1:0] pin_q_w, evt_w;
   logic [NPINS-1:0] src_clr, wsrc_clr, wake_set;
   logic [NPINS-1:0] src_q, wsrc_q;
   logic             irq_any;

   assign wr_bits = wr_data[NPINS-1:0];

   gpio_evt_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_bits),
      .ien     (ien_w),
      .rise_en (rise_en_w),
      .fall_en (fall_en_w),
      .lmode   (lmode_w),
      .llow    (llow_w),
      .wen     (wen_w)
   );

   gpio_evt_detect #(.NPINS(NPINS)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_lvl (pin_lvl),
      .rise_en (rise_en_w),
      .fall_en (fall_en_w),
      .lmode   (lmode_w),
      .llow    (llow_w),
      .pin_q   (pin_q_w),
      .evt     (evt_w)
   );

   assign src_clr  = (wr_en && wr_addr == A_SRC)  ? wr_bits : '0;
   assign wsrc_clr = (wr_en && wr_addr == A_WSRC) ? wr_bits : '0;
   assign wake_set = evt_w & wen_w;

   gpio_evt_w1c #(.NPINS(NPINS)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (evt_w),
      .clr_vec (src_clr),
      .stat_q  (src_q)
   );

   gpio_evt_w1c #(.NPINS(NPINS)) u_wsrc (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (wake_set),
      .clr_vec (wsrc_clr),
      .stat_q  (wsrc_q)
   );

   assign irq_any = |(src_q & ien_w);

   if (IRQ_OUT_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            irq_out <= 1'b0;
         else
            irq_out <= irq_any;
      end
   end else begin : g_irq_comb
      assign irq_out = irq_any;
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_SRC:   rd_data[NPINS-1:0] = src_q;
         A_IEN:   rd_data[NPINS-1:0] = ien_w;
         A_RISE:  rd_data[NPINS-1:0] = rise_en_w;
         A_FALL:  rd_data[NPINS-1:0] = fall_en_w;
         A_LMODE: rd_data[NPINS-1:0] = lmode_w;
         A_LLOW:  rd_data[NPINS-1:0] = llow_w;
         A_WEN:   rd_data[NPINS-1:0] = wen_w;
         A_WSRC:  rd_data[NPINS-1:0] = wsrc_q;
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk #(
   parameter int NPINS       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter bit IRQ_OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPINS-1:0]  pin_lvl,
   input logic [NPINS-1:0]  pin_q,
   input logic [NPINS-1:0]  rise_en,
   input logic [NPINS-1:0]  fall_en,
   input logic [NPINS-1:0]  lmode,
   input logic [NPINS-1:0]  llow,
   input logic [NPINS-1:0]  ien,
   input logic [NPINS-1:0]  wen,
   input logic [NPINS-1:0]  src_q,
   input logic [NPINS-1:0]  wsrc_q,
   input logic              irq_out,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data
);

   logic [NPINS-1:0] up_hit, dn_hit, lvl_hit, clr_seen;

   assign up_hit   = pin_lvl & ~pin_q & rise_en & ~lmode;
   assign dn_hit   = ~pin_lvl & pin_q & fall_en & ~lmode;
   assign lvl_hit  = lmode & (pin_lvl ^ llow);
   assign clr_seen = (wr_en && wr_addr == '0) ? wr_data[NPINS-1:0] : '0;

   // R1: reset leaves both status vectors empty
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (src_q == '0 && wsrc_q == '0));

   // R2 and R9: an armed rising edge is latched even under a clear
   p_rise_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_hit != '0) |=> ((src_q & $past(up_hit)) == $past(up_hit)));

   // R3: an armed falling edge is latched
   p_fall_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_hit != '0) |=> ((src_q & $past(dn_hit)) == $past(dn_hit)));

   // R5: an active level keeps its bit set every cycle
   p_level_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_hit != '0) |=> ((src_q & $past(lvl_hit)) == $past(lvl_hit)));

   // R6: set bits only drop when written with 1
   p_src_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(src_q & ~clr_seen) & ~src_q) == '0));

   // R8: new wake bits only appear on wake-enabled pins
   p_wake_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((wsrc_q & ~$past(wsrc_q) & ~$past(wen)) == '0));

   if (!IRQ_OUT_REG) begin : g_out_chk
      // R7: with every pin masked off the request stays low
      p_out_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (ien == '0) |-> !irq_out);
   end

endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(
   .NPINS       (NPINS),
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .IRQ_OUT_REG (IRQ_OUT_REG)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pin_lvl (pin_lvl),
   .pin_q   (pin_q_w),
   .rise_en (rise_en_w),
   .fall_en (fall_en_w),
   .lmode   (lmode_w),
   .llow    (llow_w),
   .ien     (ien_w),
   .wen     (wen_w),
   .src_q   (src_q),
   .wsrc_q  (wsrc_q),
   .irq_out (irq_out),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data)
);

// File: tb/gpio_evt_bank_bench.sv
module gpio_evt_bank_bench;

   localparam int N  = 32;
   localparam int AW = 3;

   localparam logic [2:0] I_SRC = 3'd0, I_IEN = 3'd1, I_RISE = 3'd2, I_FALL = 3'd3,
                          I_LMODE = 3'd4, I_LLOW = 3'd5, I_WEN = 3'd6, I_WSRC = 3'd7;

   // {pin pattern, expected source vector after that sample}
   localparam int NVEC = 8;
   localparam logic [63:0] VEC [NVEC] = '{
      {32'h0000_0001, 32'h0000_0001},
      {32'h0000_0000, 32'h0000_0001},
      {32'h0000_0F00, 32'h0000_0000},
      {32'h0000_0000, 32'h0000_0F00},
      {32'h00FF_00F0, 32'h0000_00F0},
      {32'h0000_0000, 32'h0000_0000},
      {32'hFFFF_FFFF, 32'h0000_00FF},
      {32'h0000_0000, 32'h0000_FF0F}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_lvl = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic          irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_evt_bank u_gpio_evt_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_lvl (pin_lvl),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .irq_out (irq_out)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; pin_lvl = '0; wr_en = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired got running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state at every index
      do_reset();
      for (int a = 0; a < 8; a++) rd_chk("R1 reset register", 3'(a), 32'h0);
      chk("R1 irq_out after reset", {31'h0, irq_out}, 32'h0);

      // R4: unarmed pins produce nothing
      pin_lvl = '1; tick();
      pin_lvl = '0; tick();
      rd_chk("R4 source unarmed", I_SRC, 32'h0);
      rd_chk("R4 wake unarmed", I_WSRC, 32'h0);

      // R10: configuration readback
      wr(I_IEN, 32'h8000_0001);
      wr(I_RISE, 32'h1234_5678);
      wr(I_FALL, 32'h9ABC_DEF0);
      wr(I_LMODE, 32'h0F0F_0000);
      wr(I_LLOW, 32'h00FF_00FF);
      wr(I_WEN, 32'hC003_3000);
      rd_chk("R10 mask readback", I_IEN, 32'h8000_0001);
      rd_chk("R10 rise readback", I_RISE, 32'h1234_5678);
      rd_chk("R10 fall readback", I_FALL, 32'h9ABC_DEF0);
      rd_chk("R10 mode readback", I_LMODE, 32'h0F0F_0000);
      rd_chk("R10 polarity readback", I_LLOW, 32'h00FF_00FF);
      rd_chk("R10 wake enable readback", I_WEN, 32'hC003_3000);

      // R2 / R3: vector walk of edge patterns, cleared after each step
      do_reset();
      wr(I_RISE, 32'h0000_00FF);
      wr(I_FALL, 32'h0000_FF0F);
      for (int v = 0; v < NVEC; v++) begin
         pin_lvl = VEC[v][63:32];
         tick();
         rd_chk("R2 R3 edge vector", I_SRC, VEC[v][31:0]);
         chk("R7 masked vector irq", {31'h0, irq_out}, 32'h0);
         wr(I_SRC, 32'hFFFF_FFFF);
         rd_chk("R6 cleared after vector", I_SRC, 32'h0);
      end

      // R6 / R7 / R9 on pin 5
      do_reset();
      wr(I_RISE, 32'h0000_0020);
      pin_lvl = 32'h0000_0020; tick();
      rd_chk("R2 single rise", I_SRC, 32'h0000_0020);
      pin_lvl = '0; tick();
      rd_chk("R6 latched after return", I_SRC, 32'h0000_0020);
      wr(I_SRC, 32'hFFFF_FFDF);
      rd_chk("R6 zero bits keep state", I_SRC, 32'h0000_0020);
      chk("R7 no mask no irq", {31'h0, irq_out}, 32'h0);
      wr(I_IEN, 32'h0000_0040);
      chk("R7 other bit masked", {31'h0, irq_out}, 32'h0);
      wr(I_IEN, 32'h0000_0020);
      chk("R7 enabled pending irq", {31'h0, irq_out}, 32'h1);
      pin_lvl = 32'h0000_0020;
      wr(I_SRC, 32'h0000_0020);
      rd_chk("R9 event beats clear", I_SRC, 32'h0000_0020);
      wr(I_SRC, 32'h0000_0020);
      rd_chk("R6 clear by one", I_SRC, 32'h0);
      chk("R7 irq drops", {31'h0, irq_out}, 32'h0);

      // R5 / R8 on pin 9 in level mode
      do_reset();
      wr(I_LMODE, 32'h0000_0200);
      wr(I_WEN, 32'h0000_0200);
      pin_lvl = 32'h0000_0200; tick();
      rd_chk("R5 active-high level", I_SRC, 32'h0000_0200);
      rd_chk("R8 wake without mask", I_WSRC, 32'h0000_0200);
      wr(I_SRC, 32'h0000_0200);
      rd_chk("R5 clear while active", I_SRC, 32'h0000_0200);
      wr(I_WSRC, 32'h0000_0200);
      rd_chk("R8 wake reasserts while active", I_WSRC, 32'h0000_0200);
      pin_lvl = '0; tick();
      wr(I_SRC, 32'h0000_0200);
      rd_chk("R5 clear after release", I_SRC, 32'h0);
      wr(I_WSRC, 32'h0000_0200);
      rd_chk("R8 wake cleared", I_WSRC, 32'h0);
      wr(I_LLOW, 32'h0000_0200);
      tick();
      rd_chk("R5 active-low level", I_SRC, 32'h0000_0200);
      pin_lvl = 32'h0000_0200; tick();
      wr(I_SRC, 32'h0000_0200);
      rd_chk("R5 low polarity released", I_SRC, 32'h0);
      wr(I_RISE, 32'h0000_0008);
      pin_lvl = 32'h0000_0208; tick();
      rd_chk("R2 edge beside level pin", I_SRC, 32'h0000_0008);
      rd_chk("R8 no wake for disabled pin", I_WSRC, 32'h0000_0200);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule